// File: doc/BRIEF.md
# HDLC Receive Frame Processor

This block turns one channel's bit-serial line stream into framed payload octets. It locks onto the 0x7E flag, strips the zero inserted after every run of five ones, and packs the remaining bits into octets, least significant bit first. A `bit_en` strobe qualifies each line bit, so the block can sit behind a slow or gapped line clock while running on a fast core clock.

Each octet is held back until it is known not to be part of the frame check sequence. The FCS is then checked and removed, and only payload leaves the block. The FCS is either a 16-bit CRC-CCITT or a 32-bit CRC-32, chosen per frame by `crc32_sel`. Payload appears on a byte stream that marks the first byte of each frame. After the closing flag, a separate end strobe carries a status code. That code reports whether the frame was good, or failed on its check sequence, its length limits, octet alignment, or an abort sequence.

Top module: `hdlc_rx_frame`

## Requirements
- R1: Line bits are taken LSB first and only when `bit_en` is high. Nothing is framed until the first 0x7E flag is seen. Payload octets leave on `out_valid`/`out_data`, and `out_sof` marks the first octet of a frame. `out_eof` pulses on a cycle without `out_valid` and carries `out_status`.
- R2: A zero that follows five consecutive ones is discarded and never appears in the payload.
- R3: With `crc32_sel` low at the opening flag, the last 2 octets are the CRC-CCITT FCS (poly x^16+x^12+x^5+1, preset all ones, sent as the complement, low byte first). They are never forwarded. A correct frame gives status 0 (good).
- R4: With `crc32_sel` high at the opening flag, the last 4 octets are the CRC-32 FCS (same conventions). They are never forwarded. A correct frame gives status 0.
- R5: A frame whose FCS does not check, and that has no higher-priority fault, ends with status 1.
- R6: Seven or more consecutive ones abort the current frame with status 2. The block then ignores the line until the next flag.
- R7: A frame with fewer payload octets than `min_len`, or shorter than its FCS, ends with status 3.
- R8: A frame with more payload octets than `max_len` ends with status 4.
- R9: A frame whose bit count between flags (after destuffing) is not a multiple of 8 ends with status 5.
- R10: Flags with no data between them produce no frame. A single flag may close one frame and open the next.
- R11: When several faults apply, the status takes the first one in this order: abort (2), misaligned (5), too short (3), too long (4), FCS error (1).
- R12: While reset is high and on the cycle after it, `out_valid`, `out_sof` and `out_eof` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Serial line bit |
| crc32_sel | input | 1 | FCS type, sampled at each flag: 1 = CRC-32, 0 = CRC-CCITT |
| min_len | input | 16 | Minimum payload octets |
| max_len | input | 16 | Maximum payload octets |
| out_valid | output | 1 | Payload octet valid |
| out_data | output | 8 | Payload octet |
| out_sof | output | 1 | First payload octet of a frame |
| out_eof | output | 1 | Frame end strobe |
| out_status | output | 3 | End status: 0 good, 1 FCS, 2 abort, 3 short, 4 long, 5 misaligned |

## Verification
The embedded properties are checked on every cycle. They cover that a stuffed zero never yields a data bit, that at most one line event fires per cycle, that the start marker only rides on a data beat, that the end strobe never shares a cycle with data, that the FCS hold buffer stays within its size, and that an abort returns the framer to flag hunting. Whether the check sequences and the residues are right, whether the payload bytes and their order come out intact, how length limits apply, the status priority, and the shared-flag case can only be shown by the bench. It does this by sending encoded frames and comparing the octets and statuses that come back.

// File: rtl/hrx_pkg.sv
package hrx_pkg;

    typedef enum logic [2:0] {
        ST_GOOD  = 3'd0,
        ST_FCS   = 3'd1,
        ST_ABORT = 3'd2,
        ST_SHORT = 3'd3,
        ST_LONG  = 3'd4,
        ST_ALIGN = 3'd5
    } rx_status_e;

    typedef struct packed {
        logic dv;     // destuffed data bit present
        logic db;     // its value
        logic flag;   // flag recognised
        logic abort;  // seventh consecutive one
    } line_ev_t;

    localparam int FCS16_BYTES = 2;
    localparam int FCS32_BYTES = 4;
    localparam logic [15:0] RES16 = 16'hF0B8;
    localparam logic [31:0] RES32 = 32'hDEBB20E3; // bit-reversed 0xC704DD7B
    localparam logic [15:0] POLY16_R = 16'h8408;
    localparam logic [31:0] POLY32_R = 32'hEDB88320;

    function automatic logic [31:0] fcs_step(input logic [31:0] c, input logic b,
                                             input logic m32);
        logic fb;
        logic [15:0] s16;
        logic [31:0] r;
        if (m32) begin
            fb = c[0] ^ b;
            r  = (c >> 1) ^ (fb ? POLY32_R : 32'h0);
        end else begin
            fb  = c[0] ^ b;
            s16 = (c[15:0] >> 1) ^ (fb ? POLY16_R : 16'h0);
            r   = {16'h0, s16};
        end
        return r;
    endfunction

endpackage

// File: rtl/hrx_destuff.sv
module hrx_destuff
    import hrx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     bit_en,
    input  logic     bit_in,
    output line_ev_t ev
);
    logic [2:0] ones;

    always_ff @(posedge clk) begin
        if (rst) begin
            ones <= 3'd0;
            ev   <= '0;
        end else begin
            ev <= '0;
            if (bit_en) begin
                if (bit_in) begin
                    if (ones != 3'd7) ones <= ones + 3'd1;
                    if (ones == 3'd6) ev.abort <= 1'b1;
                    else if (ones < 3'd5) begin
                        ev.dv <= 1'b1;
                        ev.db <= 1'b1;
                    end
                end else begin
                    ones <= 3'd0;
                    case (ones)
                        3'd6:       ev.flag <= 1'b1;
                        3'd5, 3'd7: ;
                        default: begin
                            ev.dv <= 1'b1;
                            ev.db <= 1'b0;
                        end
                    endcase
                end
            end
        end
    end

    AST_STUFF_DROP: assert property (@(posedge clk) disable iff (rst)
        (bit_en && !bit_in && ones == 3'd5) |=> !ev.dv); // R2
    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ev.dv, ev.flag, ev.abort})); // R10

endmodule

// File: rtl/hrx_fcs_check.sv
module hrx_fcs_check
    import hrx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    input  logic din,
    input  logic mode32,
    output logic ok
);
    logic [31:0] crc;

    always_ff @(posedge clk) begin
        if (rst || clr) crc <= '1;
        else if (en)    crc <= fcs_step(crc, din, mode32);
    end

    assign ok = mode32 ? (crc == RES32) : (crc[15:0] == RES16);

endmodule

// File: rtl/hrx_framer.sv
module hrx_framer
    import hrx_pkg::*;
#(
    parameter int LEN_W  = 16,
    parameter int HOLD_D = FCS32_BYTES
) (
    input  logic             clk,
    input  logic             rst,
    input  line_ev_t         ev,
    input  logic             crc32_sel,
    input  logic [LEN_W-1:0] min_len,
    input  logic [LEN_W-1:0] max_len,
    input  logic             fcs_ok,
    output logic             fcs_clr,
    output logic             fcs_en,
    output logic             fcs_bit,
    output logic             mode32,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_sof,
    output logic             out_eof,
    output logic [2:0]       out_status
);
    localparam int PIPE_D = 6;
    localparam int HC_W   = $clog2(HOLD_D + 1);

    typedef enum logic {HUNT, ACTIVE} fr_st_e;

    fr_st_e           st;
    logic [PIPE_D-1:0] pipe;
    logic [2:0]       pcnt;
    logic [7:0]       shreg;
    logic [2:0]       bpos;
    logic             any_bits;
    logic             sof_pend;
    logic [LEN_W-1:0] bytecnt;
    logic [HC_W-1:0]  hcnt;
    logic [7:0]       hold [HOLD_D];

    logic             commit;
    logic             byte_done;
    logic [7:0]       new_byte;
    logic [HC_W-1:0]  cap;
    logic [LEN_W-1:0] pay;
    rx_status_e       end_status;

    always_comb begin
        commit    = ev.dv && (st == ACTIVE) && (pcnt == 3'(PIPE_D));
        fcs_en    = commit;
        fcs_bit   = pipe[PIPE_D-1];
        fcs_clr   = ev.flag;
        new_byte  = {pipe[PIPE_D-1], shreg[7:1]};
        byte_done = commit && (bpos == 3'd7);
        cap       = mode32 ? HC_W'(FCS32_BYTES) : HC_W'(FCS16_BYTES);
        pay       = bytecnt - LEN_W'(cap);
        if (bpos != 3'd0)                                   end_status = ST_ALIGN;
        else if (bytecnt < LEN_W'(cap) || pay < min_len)    end_status = ST_SHORT;
        else if (pay > max_len)                             end_status = ST_LONG;
        else if (!fcs_ok)                                   end_status = ST_FCS;
        else                                                end_status = ST_GOOD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= HUNT;
            pipe       <= '0;
            pcnt       <= '0;
            shreg      <= '0;
            bpos       <= '0;
            any_bits   <= 1'b0;
            sof_pend   <= 1'b0;
            bytecnt    <= '0;
            hcnt       <= '0;
            mode32     <= 1'b0;
            out_valid  <= 1'b0;
            out_data   <= '0;
            out_sof    <= 1'b0;
            out_eof    <= 1'b0;
            out_status <= ST_GOOD;
            for (int k = 0; k < HOLD_D; k++) hold[k] <= '0;
        end else begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_eof   <= 1'b0;
            if (ev.flag) begin
                if (st == ACTIVE && any_bits) begin
                    out_eof    <= 1'b1;
                    out_status <= end_status;
                end
                st       <= ACTIVE;
                pcnt     <= '0;
                bpos     <= '0;
                any_bits <= 1'b0;
                bytecnt  <= '0;
                hcnt     <= '0;
                sof_pend <= 1'b1;
                mode32   <= crc32_sel;
            end else if (ev.abort) begin
                if (st == ACTIVE && any_bits) begin
                    out_eof    <= 1'b1;
                    out_status <= ST_ABORT;
                end
                st       <= HUNT;
                any_bits <= 1'b0;
            end else if (ev.dv && st == ACTIVE) begin
                pipe <= {pipe[PIPE_D-2:0], ev.db};
                if (pcnt != 3'(PIPE_D)) pcnt <= pcnt + 3'd1;
                if (commit) begin
                    any_bits <= 1'b1;
                    shreg    <= new_byte;
                    bpos     <= bpos + 3'd1;
                    if (byte_done) begin
                        if (bytecnt != '1) bytecnt <= bytecnt + 1'b1;
                        if (hcnt == cap) begin
                            out_valid <= 1'b1;
                            out_data  <= hold[0];
                            out_sof   <= sof_pend;
                            sof_pend  <= 1'b0;
                            for (int k = 0; k < HOLD_D - 1; k++) hold[k] <= hold[k+1];
                            hold[cap - HC_W'(1)] <= new_byte;
                        end else begin
                            hold[hcnt] <= new_byte;
                            hcnt       <= hcnt + 1'b1;
                        end
                    end
                end
            end
        end
    end

    AST_SOF_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
        out_sof |-> out_valid); // R1
    AST_EOF_NO_DATA: assert property (@(posedge clk) disable iff (rst)
        out_eof |-> !out_valid); // R1
    AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (rst)
        hcnt <= cap); // R3
    AST_ABORT_TO_HUNT: assert property (@(posedge clk) disable iff (rst)
        (ev.abort && !ev.flag) |=> (st == HUNT)); // R6

endmodule

// File: rtl/hdlc_rx_frame.sv
module hdlc_rx_frame
    import hrx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bit_en,
    input  logic        bit_in,
    input  logic        crc32_sel,
    input  logic [15:0] min_len,
    input  logic [15:0] max_len,
    output logic        out_valid,
    output logic [7:0]  out_data,
    output logic        out_sof,
    output logic        out_eof,
    output logic [2:0]  out_status
);
    line_ev_t ev;
    logic fcs_clr, fcs_en, fcs_bit, fcs_ok, mode32;

    hrx_destuff u_destuff (
        .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in), .ev(ev)
    );

    hrx_fcs_check u_fcs (
        .clk(clk), .rst(rst), .clr(fcs_clr), .en(fcs_en), .din(fcs_bit),
        .mode32(mode32), .ok(fcs_ok)
    );

    hrx_framer #(.LEN_W(16), .HOLD_D(FCS32_BYTES)) u_framer (
        .clk(clk), .rst(rst), .ev(ev), .crc32_sel(crc32_sel),
        .min_len(min_len), .max_len(max_len), .fcs_ok(fcs_ok),
        .fcs_clr(fcs_clr), .fcs_en(fcs_en), .fcs_bit(fcs_bit), .mode32(mode32),
        .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
        .out_eof(out_eof), .out_status(out_status)
    );

endmodule

// File: tb/tb_hdlc_rx_frame.sv
module tb_hdlc_rx_frame;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_en = 1'b0;
    logic        bit_in = 1'b0;
    logic        crc32_sel = 1'b0;
    logic [15:0] min_len = 16'd2;
    logic [15:0] max_len = 16'd8;
    logic        out_valid, out_sof, out_eof;
    logic [7:0]  out_data;
    logic [2:0]  out_status;

    int n_chk = 0;
    int n_bad = 0;
    int tx_ones = 0;
    int sof_cnt = 0;
    bit done = 1'b0;
    logic [7:0] txq[$];
    logic [7:0] expq[$];
    logic [7:0] rxq[$];
    int statq[$];

    always #10 clk = ~clk;

    hdlc_rx_frame dut (
        .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
        .crc32_sel(crc32_sel), .min_len(min_len), .max_len(max_len),
        .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
        .out_eof(out_eof), .out_status(out_status)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                rxq.push_back(out_data);
                if (out_sof) sof_cnt++;
            end
            if (out_eof) statq.push_back(int'(out_status));
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send_raw(input logic b);
        @(negedge clk);
        bit_en = 1'b1;
        bit_in = b;
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    task automatic send_dbit(input logic b);
        send_raw(b);
        if (b) begin
            tx_ones++;
            if (tx_ones == 5) begin
                send_raw(1'b0);
                tx_ones = 0;
            end
        end else tx_ones = 0;
    endtask

    task automatic send_flag();
        for (int i = 0; i < 8; i++) send_raw(i != 0 && i != 7);
        tx_ones = 0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_dbit(v[i]);
    endtask

    // payload from txq, FCS appended, then `extra` zero bits
    task automatic send_body(input bit m32, input bit corrupt, input int extra);
        logic [31:0] c = 32'hFFFF_FFFF;
        logic [31:0] f;
        logic fb;
        foreach (txq[j]) begin
            for (int i = 0; i < 8; i++) begin
                fb = c[0] ^ txq[j][i];
                if (m32) c = (c >> 1) ^ (fb ? 32'hEDB88320 : 32'h0);
                else     c = {16'h0, (c[15:0] >> 1) ^ (fb ? 16'h8408 : 16'h0)};
            end
            send_byte(txq[j]);
            expq.push_back(txq[j]);
        end
        f = ~c;
        if (corrupt) f[3] = ~f[3];
        for (int k = 0; k < (m32 ? 4 : 2); k++) send_byte(f[8*k +: 8]);
        for (int k = 0; k < extra; k++) send_dbit(1'b0);
    endtask

    task automatic clear_mon();
        rxq.delete();
        expq.delete();
        statq.delete();
        sof_cnt = 0;
    endtask

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    task automatic check_one(input int exp_st, input string req);
        chk(statq.size() == 1, {req, " frame count"}, statq.size(), 1);
        if (statq.size() == 1) chk(statq[0] == exp_st, {req, " status"}, statq[0], exp_st);
    endtask

    task automatic check_data(input string req);
        chk(rxq.size() == expq.size(), {req, " byte count"}, rxq.size(), expq.size());
        if (rxq.size() == expq.size())
            foreach (rxq[i]) chk(rxq[i] == expq[i], {req, " byte"}, rxq[i], expq[i]);
    endtask

    // R12: reset state
    task automatic t_reset();
        @(negedge clk);
        chk(!out_valid && !out_sof && !out_eof, "R12 outputs in reset",
            {out_valid, out_sof, out_eof}, 0);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk(!out_valid && !out_sof && !out_eof, "R12 outputs after reset",
            {out_valid, out_sof, out_eof}, 0);
    endtask

    // R1 R2 R3: junk before first flag, stuffing-heavy CCITT frame
    task automatic t_ccitt_good();
        clear_mon();
        send_raw(1); send_raw(0); send_raw(1); send_raw(1); send_raw(0); send_raw(1);
        txq = '{8'hFF, 8'h7E, 8'h3E, 8'h00};
        send_flag(); send_body(1'b0, 1'b0, 0); send_flag(); send_flag();
        settle();
        check_one(0, "R3");
        check_data("R2");
        chk(sof_cnt == 1, "R1 sof count", sof_cnt, 1);
    endtask

    // R4
    task automatic t_crc32_good();
        clear_mon();
        crc32_sel = 1'b1;
        txq = '{8'hF8, 8'h1F, 8'hA5, 8'h5A, 8'hC3};
        send_flag(); send_body(1'b1, 1'b0, 0); send_flag();
        crc32_sel = 1'b0;
        settle();
        check_one(0, "R4");
        check_data("R4");
    endtask

    // R5
    task automatic t_fcs_bad();
        clear_mon();
        txq = '{8'h12, 8'h34, 8'h56};
        send_flag(); send_body(1'b0, 1'b1, 0); send_flag();
        settle();
        check_one(1, "R5");
    endtask

    // R6: abort mid-frame, then recovery at next flag
    task automatic t_abort();
        clear_mon();
        send_flag(); send_byte(8'h41); send_byte(8'h42);
        for (int i = 0; i < 9; i++) send_raw(1'b1);
        txq = '{8'h77, 8'h88};
        send_flag(); send_body(1'b0, 1'b0, 0); send_flag();
        settle();
        chk(statq.size() == 2, "R6 frame count", statq.size(), 2);
        if (statq.size() == 2) begin
            chk(statq[0] == 2, "R6 abort status", statq[0], 2);
            chk(statq[1] == 0, "R6 recovery status", statq[1], 0);
        end
    endtask

    // R7
    task automatic t_short();
        clear_mon();
        txq = '{8'h99};
        send_flag(); send_body(1'b0, 1'b0, 0); send_flag();
        settle();
        check_one(3, "R7");
    endtask

    // R8
    task automatic t_long();
        clear_mon();
        txq = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'h09, 8'h0A};
        send_flag(); send_body(1'b0, 1'b0, 0); send_flag();
        settle();
        check_one(4, "R8");
    endtask

    // R9
    task automatic t_align();
        clear_mon();
        txq = '{8'hAB, 8'hCD, 8'hEF};
        send_flag(); send_body(1'b0, 1'b0, 3); send_flag();
        settle();
        check_one(5, "R9");
    endtask

    // R11: long beats FCS error; misaligned beats short
    task automatic t_priority();
        clear_mon();
        txq = '{8'h10, 8'h20, 8'h30, 8'h40, 8'h50, 8'h60, 8'h70, 8'h80, 8'h90};
        send_flag(); send_body(1'b0, 1'b1, 0); send_flag();
        settle();
        check_one(4, "R11 long over fcs");
        clear_mon();
        txq = '{8'h5C};
        send_flag(); send_body(1'b0, 1'b0, 2); send_flag();
        settle();
        check_one(5, "R11 align over short");
    endtask

    // R10: idle flags, shared closing/opening flag
    task automatic t_shared();
        clear_mon();
        send_flag(); send_flag(); send_flag();
        settle();
        chk(statq.size() == 0, "R10 idle flags", statq.size(), 0);
        txq = '{8'hDE, 8'hAD};
        send_flag(); send_body(1'b0, 1'b0, 0);
        txq = '{8'hBE, 8'hEF, 8'h00};
        send_flag(); send_body(1'b0, 1'b0, 0);
        send_flag(); send_flag();
        settle();
        chk(statq.size() == 2, "R10 frame count", statq.size(), 2);
        if (statq.size() == 2)
            chk(statq[0] == 0 && statq[1] == 0, "R10 statuses", statq[0] * 8 + statq[1], 0);
        chk(sof_cnt == 2, "R10 sof count", sof_cnt, 2);
        check_data("R10");
    endtask

    initial begin
        t_reset();
        t_ccitt_good();
        t_crc32_good();
        t_fcs_bad();
        t_abort();
        t_short();
        t_long();
        t_align();
        t_priority();
        t_shared();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule